// File: doc/BRIEF.md
# Write-Through Split Instruction/Data Cache Controller

This block sits between a processor core's separate instruction-fetch and data-access ports and a single, slow unified memory bus. Each port has its own small direct-mapped cache. Every line holds one 32-bit word and has a valid bit. A read that hits is answered in the same cycle. A read that misses is filled over the shared bus. Every store goes to memory. When a store address is already cached, the cached word is also patched under the byte mask. A store to an address that is not cached leaves the cache untouched.

The core sees a single `halt` line. While `halt` is high, the core holds both of its requests unchanged. Either side, or both, can raise it. If both sides need the bus in the same cycle, the data operation goes first and the instruction fill follows. A store is sent to memory once per core request, even when `halt` stays high for an instruction fill that comes after it.

Each bus transaction lasts `WAIT_STATES + 1` cycles. The address and controls stay stable for the whole transaction. `m_last` marks the final cycle, and that is the cycle in which memory commits a write or presents read data.

Top module: `wt_split_cache`

## Requirements
- R1: After reset, every line of both caches is invalid. `halt` and `m_req` are low while no request is present, and the first access to any address is a miss.
- R2: An instruction read or data read that hits returns the stored word in the same cycle, with `halt` low and no bus traffic.
- R3: A lone read miss holds `halt` high for exactly `WAIT_STATES + 2` cycles. The word is fetched over the bus and written into its line, and the core then receives the memory word.
- R4: Every store raises `halt` for `WAIT_STATES + 2` cycles, hit or miss. It writes memory with the byte enables, where `d_be[k]` qualifies bits `8k+7:8k`.
- R5: A store that hits updates only the enabled bytes of the cached word, so a following read of that address hits and returns the merged word.
- R6: A store that misses does not allocate a line, so a following read of that address misses.
- R7: When an instruction miss and a data operation are both pending in the same cycle, the data bus transaction completes first and the instruction fill follows. The total stall is `2*WAIT_STATES + 4` cycles.
- R8: A bus transaction keeps `m_req` high for exactly `WAIT_STATES + 1` consecutive cycles with a stable `m_addr`. `m_last` is high only in the final cycle, and `WAIT_STATES = 0` gives one-cycle transactions.
- R9: `halt` is high in every cycle the bus is busy. A store is issued to memory exactly once per core request, even while `halt` remains high for an instruction fill queued behind it.
- R10: Each cache is direct-mapped on address bits `[2 +: IDX_W]`. A fill to an index evicts the previous address at that index, so that address misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_req | input | 1 | Instruction fetch request |
| i_addr | input | ADDR_W | Instruction byte address (word aligned) |
| i_rdata | output | 32 | Fetched instruction word |
| d_req | input | 1 | Data access request |
| d_we | input | 1 | Data access is a store |
| d_be | input | 4 | Store byte enables |
| d_addr | input | ADDR_W | Data byte address (word aligned) |
| d_wdata | input | 32 | Store data |
| d_rdata | output | 32 | Load data |
| halt | output | 1 | Core must hold its requests this cycle |
| m_req | output | 1 | Bus transaction in progress |
| m_we | output | 1 | Bus transaction is a write |
| m_be | output | 4 | Bus byte enables |
| m_addr | output | ADDR_W | Bus byte address |
| m_wdata | output | 32 | Bus write data |
| m_rdata | input | 32 | Bus read data, sampled when `m_last` is high |
| m_last | output | 1 | Final cycle of the bus transaction |

## Verification
The two functions that can coincide are an instruction miss and a data operation (a load miss or any store) arriving in the same cycle. The bench provokes this with directed pairs and with a pseudo-random mixed stream. It records the kind of each completed bus transaction by address region. It judges that the data transaction finishes before the instruction fill, that the stall equals the sum of both penalties, and that exactly one bus write occurs for the store. Both wait-state settings, 3 and 0, run the same sequence.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;

  typedef enum logic {OP_INSTR = 1'b0, OP_DATA = 1'b1} bus_op_e;

  // Byte-lane merge: lanes with a set enable take the new value.
  function automatic logic [WORD_W-1:0] merge_bytes(input logic [WORD_W-1:0] old_w,
                                                    input logic [WORD_W-1:0] new_w,
                                                    input logic [BE_W-1:0]   be);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < BE_W; b++)
      r[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/wtc_dm_array.sv
module wtc_dm_array
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BE_W-1:0]   wr_be,
  input  logic [WORD_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - 2 - IDX_W;

  logic [LINES-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [WORD_W-1:0] dat_q [LINES];

  logic [IDX_W-1:0] r_idx, w_idx;
  logic [TAG_W-1:0] r_tag, w_tag;
  logic             unused_low;

  assign r_idx = rd_addr[2 +: IDX_W];
  assign r_tag = rd_addr[ADDR_W-1 -: TAG_W];
  assign w_idx = wr_addr[2 +: IDX_W];
  assign w_tag = wr_addr[ADDR_W-1 -: TAG_W];
  assign unused_low = ^{rd_addr[1:0], wr_addr[1:0]};

  assign rd_hit  = vld_q[r_idx] && (tag_q[r_idx] == r_tag);
  assign rd_data = dat_q[r_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[w_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[w_idx] <= w_tag;
      dat_q[w_idx] <= merge_bytes(dat_q[w_idx], wr_data, wr_be);
    end
  end

  // R3
  fill_marks_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(w_idx)] && (tag_q[$past(w_idx)] == $past(w_tag)));
endmodule

// File: rtl/wtc_bus_seq.sv
module wtc_bus_seq
  import wtc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WAIT_STATES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_req,
  input  logic [ADDR_W-1:0] i_addr,
  input  logic              i_hit,
  input  logic              d_req,
  input  logic              d_we,
  input  logic [BE_W-1:0]   d_be,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [WORD_W-1:0] d_wdata,
  input  logic              d_hit,
  output logic              halt,
  output logic              m_req,
  output logic              m_we,
  output logic [BE_W-1:0]   m_be,
  output logic [ADDR_W-1:0] m_addr,
  output logic [WORD_W-1:0] m_wdata,
  output logic              m_last,
  output logic              fill_i,
  output logic              fill_d,
  output logic              upd_d
);
  localparam int CNT_W = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_STATES);

  logic              busy_q, we_q, d_done_q;
  logic [CNT_W-1:0]  cnt_q;
  bus_op_e           op_q;
  logic [BE_W-1:0]   be_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;

  // Named internal events
  logic d_need, i_need, bus_fin;

  assign d_need  = d_req && !d_done_q && (d_we || !d_hit);
  assign i_need  = i_req && !i_hit;
  assign halt    = busy_q || d_need || i_need;
  assign bus_fin = busy_q && (cnt_q == CNT_LAST);

  assign m_req   = busy_q;
  assign m_last  = bus_fin;
  assign m_we    = we_q;
  assign m_be    = be_q;
  assign m_addr  = addr_q;
  assign m_wdata = wdata_q;

  assign fill_i = bus_fin && (op_q == OP_INSTR);
  assign fill_d = bus_fin && (op_q == OP_DATA) && !we_q;
  assign upd_d  = bus_fin && (op_q == OP_DATA) && we_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      op_q     <= OP_INSTR;
      we_q     <= 1'b0;
      be_q     <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      d_done_q <= 1'b0;
    end else if (busy_q) begin
      if (bus_fin) begin
        busy_q <= 1'b0;
        if (op_q == OP_DATA) d_done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (d_need) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      op_q    <= OP_DATA;
      we_q    <= d_we;
      be_q    <= d_we ? d_be : '1;
      addr_q  <= d_addr;
      wdata_q <= d_wdata;
    end else if (i_need) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      op_q    <= OP_INSTR;
      we_q    <= 1'b0;
      be_q    <= '1;
      addr_q  <= i_addr;
      wdata_q <= '0;
    end else begin
      d_done_q <= 1'b0;
    end
  end

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_last) |=> (m_req && $stable(m_addr)));
  // R8
  bus_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_last) |=> !m_req);
  // R7
  data_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (op_q == OP_INSTR)) |-> !d_need);
  // R4
  store_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && d_req && d_we && !d_done_q) |-> halt);
endmodule

// File: rtl/wt_split_cache.sv
module wt_split_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int I_IDX_W     = 4,
  parameter int D_IDX_W     = 4,
  parameter int WAIT_STATES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_req,
  input  logic [ADDR_W-1:0] i_addr,
  output logic [31:0]       i_rdata,
  input  logic              d_req,
  input  logic              d_we,
  input  logic [3:0]        d_be,
  input  logic [ADDR_W-1:0] d_addr,
  input  logic [31:0]       d_wdata,
  output logic [31:0]       d_rdata,
  output logic              halt,
  output logic              m_req,
  output logic              m_we,
  output logic [3:0]        m_be,
  output logic [ADDR_W-1:0] m_addr,
  output logic [31:0]       m_wdata,
  input  logic [31:0]       m_rdata,
  output logic              m_last
);
  logic i_hit, d_hit;
  logic fill_i, fill_d, upd_d;
  logic dc_wr_en;
  logic [31:0] dc_wr_data;

  assign dc_wr_en   = fill_d || (upd_d && d_hit);
  assign dc_wr_data = m_we ? m_wdata : m_rdata;

  wtc_dm_array #(.ADDR_W(ADDR_W), .IDX_W(I_IDX_W)) icache_i (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(i_addr), .rd_hit(i_hit), .rd_data(i_rdata),
    .wr_en(fill_i), .wr_addr(m_addr), .wr_be(4'hF), .wr_data(m_rdata)
  );

  wtc_dm_array #(.ADDR_W(ADDR_W), .IDX_W(D_IDX_W)) dcache_i (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(d_addr), .rd_hit(d_hit), .rd_data(d_rdata),
    .wr_en(dc_wr_en), .wr_addr(m_addr), .wr_be(m_be), .wr_data(dc_wr_data)
  );

  wtc_bus_seq #(.ADDR_W(ADDR_W), .WAIT_STATES(WAIT_STATES)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .i_req(i_req), .i_addr(i_addr), .i_hit(i_hit),
    .d_req(d_req), .d_we(d_we), .d_be(d_be), .d_addr(d_addr),
    .d_wdata(d_wdata), .d_hit(d_hit),
    .halt(halt), .m_req(m_req), .m_we(m_we), .m_be(m_be),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_last(m_last),
    .fill_i(fill_i), .fill_d(fill_d), .upd_d(upd_d)
  );
endmodule

// File: tb/wt_split_cache_tb_top.sv
module wt_split_cache_tb_top;
  localparam int LINES = 16;
  localparam int WS0 = 3;
  localparam int WS1 = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int sel = 0;
  int n_chk = 0;
  int n_fail = 0;

  logic i_req = 0, d_req = 0, d_we = 0;
  logic [31:0] i_addr = 0, d_addr = 0, d_wdata = 0;
  logic [3:0] d_be = 0;

  logic [31:0] i_rd[2], d_rd[2], m_ad[2], m_wd[2];
  logic halt_k[2], m_rq[2], m_w[2], m_lst[2];
  logic [3:0] m_b[2];
  logic [31:0] b_rdata;

  logic [31:0] mem [256];
  logic [31:0] refm [256];

  wt_split_cache #(.WAIT_STATES(WS0)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .i_req(i_req && sel == 0), .i_addr(i_addr), .i_rdata(i_rd[0]),
    .d_req(d_req && sel == 0), .d_we(d_we), .d_be(d_be), .d_addr(d_addr),
    .d_wdata(d_wdata), .d_rdata(d_rd[0]), .halt(halt_k[0]),
    .m_req(m_rq[0]), .m_we(m_w[0]), .m_be(m_b[0]), .m_addr(m_ad[0]),
    .m_wdata(m_wd[0]), .m_rdata(b_rdata), .m_last(m_lst[0]));

  wt_split_cache #(.WAIT_STATES(WS1)) dut_w0_i (
    .clk(clk), .rst_n(rst_n),
    .i_req(i_req && sel == 1), .i_addr(i_addr), .i_rdata(i_rd[1]),
    .d_req(d_req && sel == 1), .d_we(d_we), .d_be(d_be), .d_addr(d_addr),
    .d_wdata(d_wdata), .d_rdata(d_rd[1]), .halt(halt_k[1]),
    .m_req(m_rq[1]), .m_we(m_w[1]), .m_be(m_b[1]), .m_addr(m_ad[1]),
    .m_wdata(m_wd[1]), .m_rdata(b_rdata), .m_last(m_lst[1]));

  wire        halt   = halt_k[sel];
  wire [31:0] i_rdata = i_rd[sel];
  wire [31:0] d_rdata = d_rd[sel];
  wire        b_req  = m_rq[sel];
  wire        b_we   = m_w[sel];
  wire        b_last = m_lst[sel];
  wire [3:0]  b_be   = m_b[sel];
  wire [31:0] b_addr = m_ad[sel];
  wire [31:0] b_wdata = m_wd[sel];
  wire integer ws = (sel == 0) ? WS0 : WS1;

  function automatic logic [31:0] lanes(input logic [31:0] o, input logic [31:0] n, input logic [3:0] m);
    logic [31:0] mask;
    mask = {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
    return (n & mask) | (o & ~mask);
  endfunction

  // Memory slave: combinational read, write on the final bus cycle
  assign b_rdata = mem[b_addr[9:2]];
  always @(posedge clk)
    if (b_req && b_last && b_we) mem[b_addr[9:2]] <= lanes(mem[b_addr[9:2]], b_wdata, b_be);

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Bus monitor (sampled mid-cycle)
  int run = 0;
  int writes = 0;
  logic [31:0] prev_a = 0;
  bit kinds[$];
  always @(negedge clk) begin
    if (rst_n && b_req) begin
      if (run > 0) chk(b_addr == prev_a, "R8", "bus addr stable", b_addr, prev_a);
      chk(halt == 1'b1, "R9", "halt while bus busy", {31'd0, halt}, 32'd1);
      prev_a = b_addr;
      run++;
      if (b_last) begin
        chk(run == ws + 1, "R8", "bus length", run, ws + 1);
        kinds.push_back(b_addr >= 32'h200);
        if (b_we) writes++;
        run = 0;
      end
    end
  end

  // Behavioural cache shadow
  bit iv[LINES], dv[LINES];
  logic [25:0] itg[LINES], dtg[LINES];

  task automatic clear_model();
    for (int k = 0; k < LINES; k++) begin iv[k] = 0; dv[k] = 0; end
  endtask

  task automatic acc(input bit ir, input logic [31:0] ia, input bit dr, input bit dw,
                     input logic [3:0] be, input logic [31:0] da, input logic [31:0] wd,
                     input string rq);
    bit ih, dh;
    int exp_st, st;
    int ii, di;
    ii = int'(ia[5:2]);
    di = int'(da[5:2]);
    ih = iv[ii] && itg[ii] == ia[31:6];
    dh = dv[di] && dtg[di] == da[31:6];
    exp_st = 0;
    if (ir && !ih) exp_st += ws + 2;
    if (dr && (dw || !dh)) exp_st += ws + 2;
    @(negedge clk);
    i_req = ir; i_addr = ia; d_req = dr; d_we = dw; d_be = be; d_addr = da; d_wdata = wd;
    kinds.delete();
    st = 0;
    #1;
    while (halt && st < 1000) begin
      st++;
      @(negedge clk);
      #1;
    end
    chk(st == exp_st, rq, "stall cycles", st, exp_st);
    if (ir) chk(i_rdata == refm[ia[9:2]], rq, "instr data", i_rdata, refm[ia[9:2]]);
    if (dr && !dw) chk(d_rdata == refm[da[9:2]], rq, "load data", d_rdata, refm[da[9:2]]);
    if (ir && !ih) begin iv[ii] = 1; itg[ii] = ia[31:6]; end
    if (dr && !dw && !dh) begin dv[di] = 1; dtg[di] = da[31:6]; end
    if (dr && dw) refm[da[9:2]] = lanes(refm[da[9:2]], wd, be);
  endtask

  task automatic idle();
    @(negedge clk);
    i_req = 0; d_req = 0; d_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    clear_model();
  endtask

  task automatic run_suite();
    int w0;
    logic [31:0] x;
    do_reset();
    idle();
    #1;
    chk(halt == 0, "R1", "halt idle after reset", {31'd0, halt}, 0);
    chk(b_req == 0, "R1", "bus idle after reset", {31'd0, b_req}, 0);
    acc(1, 32'h000, 0, 0, 0, 0, 0, "R1");
    acc(1, 32'h000, 0, 0, 0, 0, 0, "R2");
    acc(0, 0, 1, 0, 0, 32'h200, 0, "R3");
    acc(0, 0, 1, 0, 0, 32'h200, 0, "R2");
    acc(0, 0, 1, 1, 4'b0011, 32'h200, 32'hDEADBEEF, "R4");
    chk(mem[8'h80] == refm[8'h80], "R4", "store reached memory", mem[8'h80], refm[8'h80]);
    acc(0, 0, 1, 0, 0, 32'h200, 0, "R5");
    acc(0, 0, 1, 1, 4'hF, 32'h240, 32'h12345678, "R6");
    acc(0, 0, 1, 0, 0, 32'h240, 0, "R6");
    acc(1, 32'h010, 1, 0, 0, 32'h280, 0, "R7");
    chk(kinds.size() == 2 && kinds[0] == 1 && kinds[1] == 0, "R7", "data-first order",
        {30'd0, kinds.size() > 0 ? kinds[0] : 1'b0, kinds.size() > 1 ? kinds[1] : 1'b1}, 32'd2);
    w0 = writes;
    acc(1, 32'h014, 1, 1, 4'b1100, 32'h280, 32'hCAFEF00D, "R9");
    chk(writes - w0 == 1, "R9", "single store write", writes - w0, 1);
    acc(0, 0, 1, 0, 0, 32'h280, 0, "R5");
    acc(1, 32'h040, 0, 0, 0, 0, 0, "R10");
    acc(1, 32'h000, 0, 0, 0, 0, 0, "R10");
    x = 32'h1234_5677 + sel;
    for (int n = 0; n < 40; n++) begin
      x = x * 32'd1103515245 + 32'd12345;
      acc(x[17] | x[18], {24'd0, x[5:0], 2'b00},
          x[19] | x[20], x[12], x[16:13] | 4'b0001,
          32'h200 + {22'd0, x[11:6], 2'b00}, x ^ 32'h5A5A_0F0F, "R3");
    end
    idle();
  endtask

  initial begin
    for (int k = 0; k < 256; k++) begin
      mem[k]  = (k * 32'h0101_0101) ^ 32'hA500_00C3;
      refm[k] = (k * 32'h0101_0101) ^ 32'hA500_00C3;
    end
    sel = 0;
    run_suite();
    sel = 1;
    run_suite();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule